// File: doc/BRIEF.md
# Four-Stage Instruction Sequencer with Shared Memory Port

This block moves instructions through four stages in a fixed order: fetch, decode with effective-address calculation, operand read, and execute. Each stage holds a valid bit, the instruction tag and the instruction's address. When the pipe runs freely, a new instruction enters every clock, so k instructions complete in k + 3 cycles. The instruction word comes back from memory in the same cycle as the fetch address. Its top bit marks an instruction that must read an operand from memory, and its low bits are the tag.

In the single-port build, fetch and operand read share one memory port. While the operand-read stage holds an instruction that needs memory, the port serves that instruction. Fetch then holds its address, and a bubble goes into decode. A parameter selects a two-port memory, which removes this stall.

The pipe does not predict branches. A taken branch reported by execute, or an interrupt request seen while execute holds a valid instruction, empties every younger stage. Fetch then restarts at the branch target or at a fixed interrupt vector. On an interrupt, the address at which execution should resume is latched for return.

Top module: `pipe4_ctrl`

## Requirements
- R1: While rst_n is low, if_v, id_v, of_v, ex_v, stall, flush and irq_take are 0, and fetch_addr equals RESET_PC (0 by default).
- R2: With no stall and no flush, fetch_addr rises by one each cycle. The word fetched in cycle c appears in decode in c+1, in operand read in c+2 and in execute in c+3, with its tag (instr_in bits TAG_W-1:0) and its fetch address.
- R3: opnd_addr equals the operand-read stage's address plus its tag, modulo 2^ADDR_W.
- R4: In the single-port build, opnd_rd is 1 while the operand-read stage is valid and its word had bit TAG_W set. In that cycle stall is 1 and fetch_en is 0. In the next cycle fetch_addr is unchanged and id_v is 0.
- R5: In the two-port build, stall is never 1, and fetch continues while an operand is read.
- R6: When ex_v and br_taken are both 1, flush is 1. In the next cycle fetch_addr equals br_target, and id_v, of_v and ex_v are all 0.
- R7: br_taken has no effect while ex_v is 0.
- R8: When ex_v and irq_req are both 1, irq_take and flush are 1. In the next cycle fetch_addr equals IRQ_VEC (0x80 by default), and ret_pc holds the resume address. The resume address is br_target if a branch is taken in the same cycle, and ex_pc + 1 otherwise.
- R9: irq_req has no effect while ex_v is 0; it is acted on only when a valid instruction is in execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_in | input | TAG_W+1 | Word read at fetch_addr; top bit marks an operand read |
| br_taken | input | 1 | Execute reports a taken branch |
| br_target | input | ADDR_W | Target address of the taken branch |
| irq_req | input | 1 | Interrupt request |
| fetch_addr | output | ADDR_W | Address being fetched |
| fetch_en | output | 1 | Fetch uses the memory port this cycle |
| if_v | output | 1 | Fetch stage active |
| id_v | output | 1 | Decode stage valid |
| id_tag | output | TAG_W | Decode stage tag |
| of_v | output | 1 | Operand-read stage valid |
| of_tag | output | TAG_W | Operand-read stage tag |
| opnd_addr | output | ADDR_W | Effective address of the operand read |
| opnd_rd | output | 1 | Operand read uses the memory port |
| ex_v | output | 1 | Execute stage valid |
| ex_tag | output | TAG_W | Execute stage tag |
| ex_pc | output | ADDR_W | Address of the instruction in execute |
| stall | output | 1 | Fetch held because of a port conflict |
| flush | output | 1 | Younger stages are being discarded |
| irq_take | output | 1 | Interrupt accepted this cycle |
| ret_pc | output | ADDR_W | Resume address latched at the last interrupt |

## Verification
Every internal state shows up at the ports within at most three cycles. A wrong fetch address shows in the next cycle on fetch_addr. A wrong valid bit or tag in decode reaches ex_tag two cycles later. A stall that lasts too long or ends too soon shows as a repeated or skipped fetch address, and as a misplaced bubble in execute. A flush that leaves a stage valid shows as a stray ex_v within three cycles of the redirect. Because tags are distinct per address, a misordered or duplicated instruction is visible on ex_tag.

// File: rtl/pipe4_pkg.sv
package pipe4_pkg;

  typedef enum logic [1:0] {
    REDIR_NONE   = 2'd0,
    REDIR_BRANCH = 2'd1,
    REDIR_IRQ    = 2'd2
  } redir_e;

  // effective address: base address plus instruction tag (caller truncates)
  function automatic int unsigned ea_sum(input int unsigned base, input int unsigned off);
    return base + off;
  endfunction

  // sequential successor address (caller truncates)
  function automatic int unsigned pc_step(input int unsigned pc);
    return pc + 1;
  endfunction

endpackage

// File: rtl/pipe4_ctl.sv
module pipe4_ctl #(
  parameter int ADDR_W    = 8,
  parameter bit DUAL_PORT = 1'b0,
  parameter int IRQ_VEC   = 'h80
) (
  input  logic              of_v,
  input  logic              of_needs,
  input  logic              ex_v,
  input  logic [ADDR_W-1:0] ex_pc,
  input  logic              br_taken,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              irq_req,
  output logic              opnd_rd,
  output logic              stall,
  output logic              flush,
  output pipe4_pkg::redir_e redir,
  output logic [ADDR_W-1:0] redir_pc,
  output logic [ADDR_W-1:0] resume_pc
);
  import pipe4_pkg::*;

  logic take_br;
  logic take_irq;

  assign opnd_rd  = of_v & of_needs;
  assign take_br  = ex_v & br_taken;
  assign take_irq = ex_v & irq_req;
  assign flush    = take_br | take_irq;

  generate
    if (DUAL_PORT) begin : g_two_port
      assign stall = 1'b0;
    end else begin : g_one_port
      assign stall = opnd_rd;
    end
  endgenerate

  always_comb begin
    if (take_irq)     redir = REDIR_IRQ;
    else if (take_br) redir = REDIR_BRANCH;
    else              redir = REDIR_NONE;
  end

  assign redir_pc  = take_irq ? ADDR_W'(IRQ_VEC) : br_target;
  assign resume_pc = take_br ? br_target : ADDR_W'(pc_step(32'(ex_pc)));

endmodule

// File: rtl/pipe4_fetch.sv
module pipe4_fetch #(
  parameter int ADDR_W   = 8,
  parameter int RESET_PC = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              flush,
  input  logic [ADDR_W-1:0] redir_pc,
  output logic [ADDR_W-1:0] fetch_pc,
  output logic              if_v,
  output logic              fetch_go
);
  import pipe4_pkg::*;

  assign fetch_go = if_v & ~stall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_pc <= ADDR_W'(RESET_PC);
      if_v     <= 1'b0;
    end else begin
      if_v <= 1'b1;
      if (flush)         fetch_pc <= redir_pc;
      else if (fetch_go) fetch_pc <= ADDR_W'(pc_step(32'(fetch_pc)));
    end
  end

endmodule

// File: rtl/pipe4_stages.sv
module pipe4_stages #(
  parameter int ADDR_W = 8,
  parameter int TAG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_go,
  input  logic              flush,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic [TAG_W:0]    instr_in,
  input  pipe4_pkg::redir_e redir,
  input  logic [ADDR_W-1:0] resume_pc,
  output logic              id_v,
  output logic [TAG_W-1:0]  id_tag,
  output logic              of_v,
  output logic [TAG_W-1:0]  of_tag,
  output logic              of_needs,
  output logic [ADDR_W-1:0] of_ea,
  output logic              ex_v,
  output logic [TAG_W-1:0]  ex_tag,
  output logic [ADDR_W-1:0] ex_pc,
  output logic [ADDR_W-1:0] ret_pc
);
  import pipe4_pkg::*;

  logic [ADDR_W-1:0] id_pc;
  logic              id_needs;
  logic [ADDR_W-1:0] of_pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_v <= 1'b0; id_tag <= '0; id_pc <= '0; id_needs <= 1'b0;
      of_v <= 1'b0; of_tag <= '0; of_pc <= '0; of_needs <= 1'b0; of_ea <= '0;
      ex_v <= 1'b0; ex_tag <= '0; ex_pc <= '0;
      ret_pc <= '0;
    end else begin
      // decode: takes the word returned for the current fetch address
      id_v     <= fetch_go & ~flush;
      id_pc    <= fetch_pc;
      id_tag   <= instr_in[TAG_W-1:0];
      id_needs <= instr_in[TAG_W];
      // operand read: effective address computed on entry
      of_v     <= id_v & ~flush;
      of_pc    <= id_pc;
      of_tag   <= id_tag;
      of_needs <= id_needs;
      of_ea    <= ADDR_W'(ea_sum(32'(id_pc), 32'(id_tag)));
      // execute
      ex_v     <= of_v & ~flush;
      ex_pc    <= of_pc;
      ex_tag   <= of_tag;
      if (redir == REDIR_IRQ) ret_pc <= resume_pc;
    end
  end

endmodule

// File: rtl/pipe4_ctrl.sv
module pipe4_ctrl #(
  parameter int ADDR_W    = 8,
  parameter int TAG_W     = 8,
  parameter bit DUAL_PORT = 1'b0,
  parameter int RESET_PC  = 0,
  parameter int IRQ_VEC   = 'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TAG_W:0]    instr_in,
  input  logic              br_taken,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              irq_req,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_en,
  output logic              if_v,
  output logic              id_v,
  output logic [TAG_W-1:0]  id_tag,
  output logic              of_v,
  output logic [TAG_W-1:0]  of_tag,
  output logic [ADDR_W-1:0] opnd_addr,
  output logic              opnd_rd,
  output logic              ex_v,
  output logic [TAG_W-1:0]  ex_tag,
  output logic [ADDR_W-1:0] ex_pc,
  output logic              stall,
  output logic              flush,
  output logic              irq_take,
  output logic [ADDR_W-1:0] ret_pc
);
  import pipe4_pkg::*;

  logic              of_needs;
  logic              fetch_go;
  redir_e            redir;
  logic [ADDR_W-1:0] redir_pc;
  logic [ADDR_W-1:0] resume_pc;

  pipe4_ctl #(.ADDR_W(ADDR_W), .DUAL_PORT(DUAL_PORT), .IRQ_VEC(IRQ_VEC)) u_ctl (
    .of_v(of_v), .of_needs(of_needs), .ex_v(ex_v), .ex_pc(ex_pc),
    .br_taken(br_taken), .br_target(br_target), .irq_req(irq_req),
    .opnd_rd(opnd_rd), .stall(stall), .flush(flush), .redir(redir),
    .redir_pc(redir_pc), .resume_pc(resume_pc)
  );

  pipe4_fetch #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_fetch (
    .clk(clk), .rst_n(rst_n), .stall(stall), .flush(flush),
    .redir_pc(redir_pc), .fetch_pc(fetch_addr), .if_v(if_v), .fetch_go(fetch_go)
  );

  pipe4_stages #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_stages (
    .clk(clk), .rst_n(rst_n), .fetch_go(fetch_go), .flush(flush),
    .fetch_pc(fetch_addr), .instr_in(instr_in), .redir(redir), .resume_pc(resume_pc),
    .id_v(id_v), .id_tag(id_tag), .of_v(of_v), .of_tag(of_tag), .of_needs(of_needs),
    .of_ea(opnd_addr), .ex_v(ex_v), .ex_tag(ex_tag), .ex_pc(ex_pc), .ret_pc(ret_pc)
  );

  assign fetch_en = fetch_go;
  assign irq_take = (redir == REDIR_IRQ);

endmodule

// File: rtl/pipe4_ctrl_chk.sv
module pipe4_ctrl_chk #(
  parameter int ADDR_W    = 8,
  parameter int TAG_W     = 8,
  parameter bit DUAL_PORT = 1'b0,
  parameter int IRQ_VEC   = 'h80
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              fetch_en,
  input logic              if_v,
  input logic              id_v,
  input logic [TAG_W-1:0]  id_tag,
  input logic              of_v,
  input logic [TAG_W-1:0]  of_tag,
  input logic              opnd_rd,
  input logic              ex_v,
  input logic [ADDR_W-1:0] ex_pc,
  input logic              br_taken,
  input logic              stall,
  input logic              flush,
  input logic              irq_take,
  input logic [ADDR_W-1:0] ret_pc
);

  a_r1_reset_empty: assert property (@(posedge clk)
    !rst_n |=> (!id_v && !of_v && !ex_v));

  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (if_v && !stall && !flush) |=> fetch_addr == ADDR_W'($past(fetch_addr) + 1));

  a_r2_id_to_of: assert property (@(posedge clk) disable iff (!rst_n)
    (id_v && !flush) |=> (of_v && of_tag == $past(id_tag)));

  a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !flush) |=> ($stable(fetch_addr) && !id_v));

  generate
    if (DUAL_PORT) begin : g_dp
      a_r5_no_stall: assert property (@(posedge clk) disable iff (!rst_n) !stall);
    end else begin : g_sp
      a_r4_port_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(opnd_rd && fetch_en));
    end
  endgenerate

  a_r6_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!id_v && !of_v && !ex_v));

  a_r7_r9_need_ex: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_v |-> (!flush && !irq_take));

  a_r8_vector: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> fetch_addr == ADDR_W'(IRQ_VEC));

  a_r8_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && !br_taken) |=> ret_pc == ADDR_W'($past(ex_pc) + 1));

endmodule

bind pipe4_ctrl pipe4_ctrl_chk #(
  .ADDR_W(ADDR_W), .TAG_W(TAG_W), .DUAL_PORT(DUAL_PORT), .IRQ_VEC(IRQ_VEC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .fetch_en(fetch_en),
  .if_v(if_v), .id_v(id_v), .id_tag(id_tag), .of_v(of_v), .of_tag(of_tag),
  .opnd_rd(opnd_rd), .ex_v(ex_v), .ex_pc(ex_pc), .br_taken(br_taken),
  .stall(stall), .flush(flush), .irq_take(irq_take), .ret_pc(ret_pc)
);

// File: tb/test_pipe4_ctrl.sv
`timescale 1ns/1ps
module test_pipe4_ctrl;
  localparam int AW = 8;
  localparam int TW = 8;
  localparam int VEC = 'h80;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic          br_taken, irq_req;
  logic [AW-1:0] br_target;
  logic [TW:0]   mem [256];

  logic [AW-1:0] fetch_addr, opnd_addr, ex_pc, ret_pc;
  logic          fetch_en, if_v, id_v, of_v, ex_v, opnd_rd, stall, flush, irq_take;
  logic [TW-1:0] id_tag, of_tag, ex_tag;
  logic [TW:0]   instr, instr_dp;

  logic [AW-1:0] d_fetch_addr, d_opnd_addr, d_ex_pc, d_ret_pc;
  logic          d_fetch_en, d_if_v, d_id_v, d_of_v, d_ex_v, d_opnd_rd, d_stall, d_flush, d_irq_take;
  logic [TW-1:0] d_id_tag, d_of_tag, d_ex_tag;

  assign instr    = mem[fetch_addr];
  assign instr_dp = mem[d_fetch_addr];

  pipe4_ctrl #(.ADDR_W(AW), .TAG_W(TW), .DUAL_PORT(1'b0), .IRQ_VEC(VEC)) i_pipe4_ctrl (
    .clk(clk), .rst_n(rst_n), .instr_in(instr), .br_taken(br_taken), .br_target(br_target),
    .irq_req(irq_req), .fetch_addr(fetch_addr), .fetch_en(fetch_en), .if_v(if_v),
    .id_v(id_v), .id_tag(id_tag), .of_v(of_v), .of_tag(of_tag), .opnd_addr(opnd_addr),
    .opnd_rd(opnd_rd), .ex_v(ex_v), .ex_tag(ex_tag), .ex_pc(ex_pc), .stall(stall),
    .flush(flush), .irq_take(irq_take), .ret_pc(ret_pc)
  );

  pipe4_ctrl #(.ADDR_W(AW), .TAG_W(TW), .DUAL_PORT(1'b1), .IRQ_VEC(VEC)) i_pipe4_ctrl_dp (
    .clk(clk), .rst_n(rst_n), .instr_in(instr_dp), .br_taken(1'b0), .br_target('0),
    .irq_req(1'b0), .fetch_addr(d_fetch_addr), .fetch_en(d_fetch_en), .if_v(d_if_v),
    .id_v(d_id_v), .id_tag(d_id_tag), .of_v(d_of_v), .of_tag(d_of_tag), .opnd_addr(d_opnd_addr),
    .opnd_rd(d_opnd_rd), .ex_v(d_ex_v), .ex_tag(d_ex_tag), .ex_pc(d_ex_pc), .stall(d_stall),
    .flush(d_flush), .irq_take(d_irq_take), .ret_pc(d_ret_pc)
  );

  int tests = 0;
  int fails = 0;

  function automatic logic [TW-1:0] tagf(input int a);
    return TW'((a * 7 + 3) % 256);
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic load_mem(input int opnd_at);
    for (int a = 0; a < 256; a++)
      mem[a] = {(a == opnd_at) ? 1'b1 : 1'b0, tagf(a)};
  endtask

  // reset, check the idle state, release; returns positioned before cycle 0
  task automatic do_reset();
    rst_n = 1'b0; br_taken = 1'b0; br_target = '0; irq_req = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R1 if_v", 32'(if_v), 0);
    chk("R1 valids", {29'd0, id_v, of_v, ex_v}, 0);
    chk("R1 stall/flush/irq", {29'd0, stall, flush, irq_take}, 0);
    chk("R1 fetch_addr", 32'(fetch_addr), 0);
    rst_n = 1'b1;
    @(posedge clk);
  endtask

  initial begin
    #(5.0 * 20000);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // ---- Test A: free-running flow, sweep of cycles 0..40
    load_mem(-1);
    do_reset();
    for (int n = 0; n <= 40; n++) begin
      @(negedge clk); #1;
      chk("R2 fetch_addr", 32'(fetch_addr), 32'(n));
      chk("R2 id_v", 32'(id_v), 32'(n >= 1));
      chk("R2 ex_v", 32'(ex_v), 32'(n >= 3));
      if (n >= 1) chk("R2 id_tag", 32'(id_tag), 32'(tagf(n - 1)));
      if (n >= 2) begin
        chk("R2 of_tag", 32'(of_tag), 32'(tagf(n - 2)));
        chk("R3 opnd_addr", 32'(opnd_addr), 32'((n - 2 + tagf(n - 2)) % 256));
      end
      if (n >= 3) begin
        chk("R2 ex_tag", 32'(ex_tag), 32'(tagf(n - 3)));
        chk("R2 ex_pc", 32'(ex_pc), 32'(n - 3));
      end
      chk("R2 no stall", 32'(stall), 0);
    end

    // ---- Test B: operand read at address 5, one-port and two-port builds
    load_mem(5);
    do_reset();
    for (int n = 0; n <= 12; n++) begin
      @(negedge clk); #1;
      case (n)
        7: begin
          chk("R4 opnd_rd", 32'(opnd_rd), 1);
          chk("R4 stall", 32'(stall), 1);
          chk("R4 fetch_en", 32'(fetch_en), 0);
          chk("R3 opnd_addr", 32'(opnd_addr), 32'((5 + tagf(5)) % 256));
          chk("R5 dp stall", 32'(d_stall), 0);
          chk("R5 dp fetch_en", 32'(d_fetch_en), 1);
        end
        8: begin
          chk("R4 fetch held", 32'(fetch_addr), 7);
          chk("R4 bubble id", 32'(id_v), 0);
          chk("R4 ex_pc", 32'(ex_pc), 5);
          chk("R5 dp fetch_addr", 32'(d_fetch_addr), 8);
          chk("R5 dp id_v", 32'(d_id_v), 1);
        end
        9:  chk("R4 id_tag after", 32'(id_tag), 32'(tagf(7)));
        10: begin
          chk("R4 bubble ex", 32'(ex_v), 0);
          chk("R5 dp ex_tag", 32'(d_ex_tag), 32'(tagf(7)));
        end
        11: chk("R4 ex_tag", 32'(ex_tag), 32'(tagf(7)));
        12: chk("R4 fetch resumes", 32'(fetch_addr), 11);
        default: ;
      endcase
      if (n != 7) chk("R4 stall only once", 32'(stall), 0);
    end

    // ---- Test C: branch ignored without ex_v, then taken branch at address 10
    load_mem(-1);
    do_reset();
    for (int n = 0; n <= 17; n++) begin
      @(negedge clk);
      br_taken  = (n <= 2) || (n == 13);
      br_target = (n <= 2) ? 8'd99 : 8'd40;
      #1;
      if (n <= 2) chk("R7 no flush", 32'(flush), 0);
      if (n == 3) chk("R7 fetch_addr", 32'(fetch_addr), 3);
      if (n == 13) begin
        chk("R6 ex_pc", 32'(ex_pc), 10);
        chk("R6 flush", 32'(flush), 1);
      end
      if (n == 14) begin
        chk("R6 fetch_addr", 32'(fetch_addr), 40);
        chk("R6 empty", {29'd0, id_v, of_v, ex_v}, 0);
      end
      if (n == 15) chk("R6 id_tag", 32'(id_tag), 32'(tagf(40)));
      if (n == 17) chk("R6 ex_pc target", 32'(ex_pc), 40);
    end
    br_taken = 1'b0;

    // ---- Test D: interrupt waits for ex_v, then interrupt together with branch
    do_reset();
    for (int n = 0; n <= 10; n++) begin
      @(negedge clk);
      irq_req   = (n >= 1 && n <= 3) || (n == 9);
      br_taken  = (n == 9);
      br_target = 8'd30;
      #1;
      if (n == 1 || n == 2) chk("R9 no take", {30'd0, flush, irq_take}, 0);
      if (n == 3) chk("R8 take", {30'd0, flush, irq_take}, 3);
      if (n == 4) begin
        chk("R8 vector", 32'(fetch_addr), VEC);
        chk("R8 ret_pc", 32'(ret_pc), 1);
        chk("R8 empty", 32'(ex_v), 0);
      end
      if (n == 7) chk("R8 ex at vector", 32'(ex_pc), VEC);
      if (n == 9) chk("R8 ex_pc", 32'(ex_pc), VEC + 2);
      if (n == 10) begin
        chk("R8 vector again", 32'(fetch_addr), VEC);
        chk("R8 ret_pc branch", 32'(ret_pc), 30);
      end
    end
    irq_req = 1'b0; br_taken = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule